// File: doc/BRIEF.md
# Balanced Line Frame Encoder

This block turns a parallel word into one fixed-length line frame per frame clock for a synchronous serial link. It sits in front of a serializer and behind a user interface that offers a word together with a valid strobe, a control strobe and an extra flag bit. Each frame starts with a four-bit coding field. The field holds a fixed one-then-zero alignment edge and a two-bit type code, so the far end can tell data, control, idle fill and training frames apart without any framing words from the user.

The block keeps the line DC balanced for any data pattern. It tracks a signed running disparity and inverts the invertible field of a frame (payload plus flag) whenever sending it unchanged would push the disparity further from zero. It marks such frames with an inversion bit. A static width input picks a 16-bit or a 20-bit payload. A static flag-mode input decides whether the flag carries user data, an even/odd frame toggle or a parity check bit. A training request replaces all traffic with one of two training fills for the link start-up handshake.

Top module: `enc_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, the output frame is an idle fill with inversion bit 0, flag 0 and an all-zero payload. The running disparity starts at zero and the even/odd toggle starts at even (0).
- R2: The frame is 26 bits wide. Bits [25:24] are always 2'b10, bits [23:22] hold the type (00 data, 01 control, 10 fill, 11 training), bit [21] is the inversion bit, bit [20] is the flag and bits [19:0] are the payload. A frame appears on the output one clock after its inputs are sampled.
- R3: With `wide_i`=1 the payload is 20 bits. With `wide_i`=0 it is 16 bits, and bits [19:16] of the frame are always 0 and are never inverted.
- R4: In flag mode 2'b00 (user), the flag carries `flag_i` on data and control frames and is 0 on fill and training frames (before inversion).
- R5: In flag mode 2'b01 (toggle), data frames carry the even/odd toggle, and the toggle flips after every data frame. All other frames carry flag 0 (before inversion).
- R6: In flag modes 2'b10 and 2'b11 (check), the flag is the XOR of the active payload bits before inversion, on every frame type.
- R7: When no training, control or valid request is present, the frame is a fill (type 10) with an all-zero payload before inversion.
- R8: `train_req_i` overrides control and data. The frame is type 11, payload bit 0 equals `train_sel_i` (0 = first training fill, 1 = second) and all other payload bits are 0 before inversion.
- R9: `ctrl_i` overrides `valid_i`. The frame is type 01 and carries only the low 14 bits (16-bit mode) or the low 18 bits (20-bit mode) of `data_i`. The higher payload bits are 0 before inversion.
- R10: The invertible field is the flag plus the active payload bits. Its disparity is the number of ones minus the number of zeros. The field is inverted, with bit [21] set, exactly when the running disparity is nonzero and the field's disparity has the same sign. The running disparity then adds the disparity actually sent, and its magnitude never exceeds 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wide_i | input | 1 | Static width select: 1 = 20-bit payload, 0 = 16-bit payload |
| flag_mode_i | input | 2 | Static flag mode: 00 user, 01 toggle, 1x check |
| data_i | input | 20 | Parallel word |
| flag_i | input | 1 | User flag bit |
| valid_i | input | 1 | Word offered as data this slot |
| ctrl_i | input | 1 | Word offered as control this slot |
| train_req_i | input | 1 | Send a training fill this slot |
| train_sel_i | input | 1 | Selects which training fill |
| frame_o | output | 26 | Encoded line frame |

## Verification
The hardest case to reach from the ports is the inversion decision when the running disparity sits at its extremes. The field's disparity must then share the sign of a disparity built up by earlier frames. The stimulus drives long runs of all-ones and all-zeros words, and runs of fills, so that the disparity keeps swinging to plus or minus 21. Odd and mixed patterns in between make sure both the invert and the keep outcomes occur in each sign. A running total of the disparity sent, rebuilt from the observed frames, must stay within its bound.

// File: rtl/enc_pkg.sv
package enc_pkg;
  typedef enum logic [1:0] {
    FT_DATA  = 2'b00,
    FT_CTRL  = 2'b01,
    FT_FILL  = 2'b10,
    FT_TRAIN = 2'b11
  } ftype_e;

  typedef enum logic [1:0] {
    FM_USER   = 2'b00,
    FM_TOGGLE = 2'b01,
    FM_CHECK  = 2'b10,
    FM_CHECK2 = 2'b11
  } fmode_e;

  localparam logic [1:0] ALIGN_EDGE = 2'b10;
endpackage

// File: rtl/frm_compose.sv
module frm_compose
  import enc_pkg::*;
#(
  parameter int WIDE_W        = 20,
  parameter int NARROW_W      = 16,
  parameter int CTRL_WIDE_W   = 18,
  parameter int CTRL_NARROW_W = 14
) (
  input  logic              wide_i,
  input  fmode_e            fmode_i,
  input  logic [WIDE_W-1:0] data_i,
  input  logic              flag_i,
  input  logic              valid_i,
  input  logic              ctrl_i,
  input  logic              train_i,
  input  logic              train_sel_i,
  input  logic              toggle_i,
  output ftype_e            ftype_o,
  output logic [WIDE_W-1:0] payload_o,
  output logic [WIDE_W-1:0] act_mask_o,
  output logic              flag_o
);
  logic [WIDE_W-1:0] ctl_mask;
  int                ctl_len;

  always_comb begin
    ctl_len = wide_i ? CTRL_WIDE_W : CTRL_NARROW_W;
    for (int i = 0; i < WIDE_W; i++) begin
      act_mask_o[i] = wide_i || (i < NARROW_W);
      ctl_mask[i]   = (i < ctl_len);
    end
  end

  // priority: training, then control, then data, else fill
  always_comb begin
    payload_o = '0;
    if (train_i) begin
      ftype_o      = FT_TRAIN;
      payload_o[0] = train_sel_i;
    end else if (ctrl_i) begin
      ftype_o   = FT_CTRL;
      payload_o = data_i & ctl_mask;
    end else if (valid_i) begin
      ftype_o   = FT_DATA;
      payload_o = data_i & act_mask_o;
    end else begin
      ftype_o = FT_FILL;
    end
  end

  always_comb begin
    case (fmode_i)
      FM_USER:   flag_o = flag_i && (ftype_o == FT_DATA || ftype_o == FT_CTRL);
      FM_TOGGLE: flag_o = toggle_i && (ftype_o == FT_DATA);
      default:   flag_o = ^(payload_o & act_mask_o);
    endcase
  end
endmodule

// File: rtl/frm_balance.sv
module frm_balance #(
  parameter int WIDE_W = 20,
  parameter int RD_W   = 8
) (
  input  logic                   [WIDE_W-1:0] payload_i,
  input  logic                   [WIDE_W-1:0] act_mask_i,
  input  logic                                flag_i,
  input  logic signed            [RD_W-1:0]   rd_i,
  output logic                   [WIDE_W-1:0] payload_o,
  output logic                                flag_o,
  output logic                                inv_o,
  output logic signed            [RD_W-1:0]   rd_next_o
);
  logic        [RD_W-1:0] ones;
  logic        [RD_W-1:0] nbits;
  logic signed [RD_W-1:0] disp;

  always_comb begin
    ones  = RD_W'(flag_i);
    nbits = RD_W'(1);
    for (int i = 0; i < WIDE_W; i++) begin
      ones  = ones + RD_W'(payload_i[i] & act_mask_i[i]);
      nbits = nbits + RD_W'(act_mask_i[i]);
    end
    disp = $signed(ones) + $signed(ones) - $signed(nbits);
  end

  always_comb begin
    inv_o     = (rd_i != '0) && (disp[RD_W-1] == rd_i[RD_W-1]);
    payload_o = inv_o ? (payload_i ^ act_mask_i) : payload_i;
    flag_o    = flag_i ^ inv_o;
    rd_next_o = inv_o ? (rd_i - disp) : (rd_i + disp);
  end
endmodule

// File: rtl/enc_frame_tx.sv
module enc_frame_tx
  import enc_pkg::*;
#(
  parameter int WIDE_W        = 20,
  parameter int NARROW_W      = 16,
  parameter int CTRL_WIDE_W   = 18,
  parameter int CTRL_NARROW_W = 14,
  localparam int FRAME_W      = WIDE_W + 6,
  localparam int RD_W         = $clog2(WIDE_W + 2) + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wide_i,
  input  logic [1:0]         flag_mode_i,
  input  logic [WIDE_W-1:0]  data_i,
  input  logic               flag_i,
  input  logic               valid_i,
  input  logic               ctrl_i,
  input  logic               train_req_i,
  input  logic               train_sel_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [FRAME_W-1:0] IDLE_FRAME = {ALIGN_EDGE, FT_FILL, 1'b0, 1'b0, {WIDE_W{1'b0}}};

  logic [FRAME_W-1:0]     frame_q, frame_d;
  logic signed [RD_W-1:0] rd_q, rd_d;
  logic                   tog_q, tog_d;
  logic                   frame_en;

  ftype_e            ftype;
  logic [WIDE_W-1:0] raw_payload, act_mask, out_payload;
  logic              raw_flag, out_flag, inv;

  frm_compose #(
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W),
    .CTRL_WIDE_W(CTRL_WIDE_W), .CTRL_NARROW_W(CTRL_NARROW_W)
  ) u_compose (
    .wide_i(wide_i), .fmode_i(fmode_e'(flag_mode_i)), .data_i(data_i),
    .flag_i(flag_i), .valid_i(valid_i), .ctrl_i(ctrl_i),
    .train_i(train_req_i), .train_sel_i(train_sel_i), .toggle_i(tog_q),
    .ftype_o(ftype), .payload_o(raw_payload), .act_mask_o(act_mask),
    .flag_o(raw_flag)
  );

  frm_balance #(.WIDE_W(WIDE_W), .RD_W(RD_W)) u_balance (
    .payload_i(raw_payload), .act_mask_i(act_mask), .flag_i(raw_flag),
    .rd_i(rd_q), .payload_o(out_payload), .flag_o(out_flag),
    .inv_o(inv), .rd_next_o(rd_d)
  );

  // one frame per frame clock
  assign frame_en = 1'b1;

  always_comb begin
    frame_d = {ALIGN_EDGE, ftype, inv, out_flag, out_payload};
    tog_d   = tog_q ^ (ftype == FT_DATA);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= IDLE_FRAME;
      rd_q    <= '0;
      tog_q   <= 1'b0;
    end else if (frame_en) begin
      frame_q <= frame_d;
      rd_q    <= rd_d;
      tog_q   <= tog_d;
    end
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/enc_frame_tx_chk.sv
module enc_frame_tx_chk #(
  parameter int WIDE_W   = 20,
  parameter int NARROW_W = 16,
  parameter int RD_W     = 8,
  localparam int FRAME_W = WIDE_W + 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wide,
  input logic                   valid,
  input logic                   ctrl,
  input logic                   train,
  input logic                   train_sel,
  input logic [FRAME_W-1:0]     frame,
  input logic signed [RD_W-1:0] rd
);
  localparam int TYPE_HI = WIDE_W + 3;
  localparam int INV_POS = WIDE_W + 1;
  localparam int RD_MAX  = WIDE_W + 1;

  a_r7_fill_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !ctrl && !train) |=> frame[TYPE_HI -: 2] == 2'b10);

  a_r8_train_wins: assert property (@(posedge clk) disable iff (!rst_n)
    train |=> (frame[TYPE_HI -: 2] == 2'b11) && ((frame[0] ^ frame[INV_POS]) == $past(train_sel)));

  a_r9_ctrl_over_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl && !train) |=> frame[TYPE_HI -: 2] == 2'b01);

  a_r3_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |=> frame[WIDE_W-1:NARROW_W] == '0);

  a_r10_rd_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (rd <= RD_W'(RD_MAX)) && (rd >= -RD_W'(RD_MAX)));

  a_r10_no_inv_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd == '0) |=> !frame[INV_POS]);
endmodule

bind enc_frame_tx enc_frame_tx_chk #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .RD_W(RD_W)
) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .wide(wide_i), .valid(valid_i), .ctrl(ctrl_i),
  .train(train_req_i), .train_sel(train_sel_i), .frame(frame_o), .rd(rd_q)
);

// File: tb/sim_enc_frame_tx.sv
module sim_enc_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide;
  logic [1:0]  fmode;
  logic [19:0] data;
  logic        flag, valid, ctrl, train, tsel;
  logic [25:0] frame;

  int errors = 0;
  int checks = 0;
  int m_rd   = 0;
  bit m_tog  = 0;
  int obs_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .flag_mode_i(fmode),
    .data_i(data), .flag_i(flag), .valid_i(valid), .ctrl_i(ctrl),
    .train_req_i(train), .train_sel_i(tsel), .frame_o(frame)
  );

  task automatic check(string tag, logic [25:0] got, logic [25:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: frame got %h expected %h", tag, got, exp);
    end
  endtask

  // apply one slot, compute expected frame from the requirements, compare
  task automatic step(string tag, bit v, bit c, bit t, bit ts, logic [19:0] d, bit f);
    logic [19:0] pl, am;
    logic [1:0]  ty;
    bit          fl, iv;
    int          n, ones, dsp, clen;
    valid = v; ctrl = c; train = t; tsel = ts; data = d; flag = f;
    @(negedge clk);
    n    = wide ? 20 : 16;
    clen = wide ? 18 : 14;
    am   = '0;
    for (int i = 0; i < n; i++) am[i] = 1'b1;
    pl = '0;
    if (t) begin ty = 2'b11; pl[0] = ts; end
    else if (c) begin ty = 2'b01; for (int i = 0; i < clen; i++) pl[i] = d[i]; end
    else if (v) begin ty = 2'b00; pl = d & am; end
    else ty = 2'b10;
    if (fmode == 2'b00) fl = f && (ty == 2'b00 || ty == 2'b01);
    else if (fmode == 2'b01) fl = m_tog && (ty == 2'b00);
    else fl = ^pl;
    ones = fl;
    for (int i = 0; i < n; i++) ones += pl[i];
    dsp = 2 * ones - (n + 1);
    iv  = (m_rd != 0) && ((dsp < 0) == (m_rd < 0));
    if (iv) begin pl = pl ^ am; fl = !fl; dsp = -dsp; end
    m_rd += dsp;
    if (ty == 2'b00) m_tog = !m_tog;
    check(tag, frame, {2'b10, ty, iv, fl, pl});
    ones = frame[20];
    for (int i = 0; i < n; i++) ones += frame[i];
    obs_rd += 2 * ones - (n + 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wide = 1'b1; fmode = 2'b00;
    valid = 0; ctrl = 0; train = 0; tsel = 0; data = '0; flag = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", frame, {2'b10, 2'b10, 1'b0, 1'b0, 20'h0});
    rst_n = 1'b1;
    step("R1 first fill", 0, 0, 0, 0, 20'h0, 0);
  endtask

  task automatic t_data_wide;
    wide = 1; fmode = 2'b00;
    step("R2 data a", 1, 0, 0, 0, 20'hA5C3F, 1);
    step("R2 data b", 1, 0, 0, 0, 20'h00F01, 0);
    step("R2 data c", 1, 0, 0, 0, 20'hFFFFE, 1);
  endtask

  task automatic t_narrow;
    wide = 0;
    step("R3 narrow hi bits", 1, 0, 0, 0, 20'hFFFFF, 1);
    step("R3 narrow zeros", 1, 0, 0, 0, 20'hF0000, 0);
    step("R3 narrow mix", 1, 0, 0, 0, 20'h51234, 1);
    wide = 1;
  endtask

  task automatic t_user_flag;
    fmode = 2'b00;
    step("R4 user flag data", 1, 0, 0, 0, 20'h12345, 1);
    step("R4 user flag ctrl", 0, 1, 0, 0, 20'h00777, 1);
    step("R4 user flag fill", 0, 0, 0, 0, 20'h0, 1);
  endtask

  task automatic t_toggle;
    fmode = 2'b01;
    for (int k = 0; k < 4; k++) step("R5 toggle data", 1, 0, 0, 0, 20'h0F0F0 + 20'(k), 0);
    step("R5 toggle ctrl", 0, 1, 0, 0, 20'h3, 1);
    step("R5 toggle after ctrl", 1, 0, 0, 0, 20'h8, 0);
  endtask

  task automatic t_check;
    fmode = 2'b10;
    step("R6 parity odd", 1, 0, 0, 0, 20'h00007, 0);
    step("R6 parity even", 1, 0, 0, 0, 20'h00003, 1);
    fmode = 2'b11;
    step("R6 parity train2", 0, 0, 1, 1, 20'h0, 0);
    wide = 0;
    step("R6 parity narrow", 1, 0, 0, 0, 20'hF0001, 0);
    wide = 1;
  endtask

  task automatic t_fill;
    fmode = 2'b00;
    for (int k = 0; k < 3; k++) step("R7 idle fill", 0, 0, 0, 0, 20'hABCDE, 1);
  endtask

  task automatic t_train;
    step("R8 train1", 0, 0, 1, 0, 20'hFFFFF, 1);
    step("R8 train2 over ctrl", 1, 1, 1, 1, 20'h12345, 1);
    step("R8 train1 over data", 1, 0, 1, 0, 20'h55555, 0);
  endtask

  task automatic t_ctrl;
    wide = 1;
    step("R9 ctrl wide mask", 0, 1, 0, 0, 20'hFFFFF, 0);
    step("R9 ctrl over data", 1, 1, 0, 0, 20'hC0001, 0);
    wide = 0;
    step("R9 ctrl narrow mask", 0, 1, 0, 0, 20'hFFFFF, 0);
    wide = 1;
  endtask

  task automatic t_balance;
    fmode = 2'b00;
    for (int k = 0; k < 6; k++) begin
      step("R10 all ones", 1, 0, 0, 0, 20'hFFFFF, 1);
      checks++;
      if (obs_rd > 21 || obs_rd < -21) begin
        errors++;
        $display("FAIL R10: running disparity got %0d expected within +-21", obs_rd);
      end
    end
    for (int k = 0; k < 6; k++) begin
      step("R10 all zeros", 1, 0, 0, 0, 20'h0, 0);
      step("R10 mostly ones", 1, 0, 0, 0, 20'hFFF0F, 0);
      checks++;
      if (obs_rd > 21 || obs_rd < -21) begin
        errors++;
        $display("FAIL R10: running disparity got %0d expected within +-21", obs_rd);
      end
    end
  endtask

  initial begin
    t_reset;
    t_data_wide;
    t_narrow;
    t_user_flag;
    t_toggle;
    t_check;
    t_fill;
    t_train;
    t_ctrl;
    t_balance;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule